// File: doc/BRIEF.md
# Node Interrupt Control Registers

This block gathers the interrupt sources of one processor node in a two-node system and presents them as two registers on a simple CSR bus. The request register holds three things. The first is a level that any bus master can set or clear to interrupt this node's processor. The second is a sticky halt request for this node only. The third is one spare scratch bit. The clear register reports the latched state of three asynchronous active-low event lines: a transaction error, a bus system event and a shared interval-timer tick. Software clears each of these by writing a one to its bit. The same register is the only place where the halt request can be removed.

Each event line passes through a synchronizer, and its falling edge sets a latch. The latch stays set until software clears it. An edge that arrives in the same cycle as the clear wins, so no event is lost. The halt request and the latched bus system event share one system-event interrupt output. Software reads the clear register to tell which of the two caused it.

The two nodes receive the same timer tick but must not take their timer interrupts together. A node-select input picks the timing. Node 0 latches the tick at its falling edge. Node 1 measures the tick period and latches a quarter period later.

Top module: `node_irq_ctrl`

## Requirements
- R1: While reset is high, every request bit, the scratch bit, every latched event and every interrupt output go to 0 on the clock edge.
- R2: A write to the request register copies data bit 0 into the interprocessor request. The request drives `ipi_irq` from the next cycle on, and bit 0 of a read returns it.
- R3: Writing 1 to request-register bit 1 sets the halt request. Writing 0 there leaves it unchanged, and bit 1 of a read returns it.
- R4: The halt request clears only when 1 is written to clear-register bit 3. `sysevt_irq` is high while the halt request or the latched bus system event is set.
- R5: A falling edge on `err_n`, `sysevt_n` or `tmr_n` sets that line's latch on the third rising clock edge after the low level is first sampled. Rising edges and steady levels set nothing. `err_irq` follows the error latch.
- R6: Writing 1 to clear-register bit 0 (error), bit 1 (bus system event) or bit 2 (timer) clears that latch. Writing 0 to one of these bits leaves its latch unchanged.
- R7: When a latch's set edge and a clear of that latch fall in the same cycle, the latch stays set.
- R8: A read of the clear register returns the error, bus system event and timer latches in bits 0 to 2 and the halt request in bit 3.
- R9: Request-register bit 2 is a scratch bit that returns the last value written to it. All other bits of both registers read 0. Writes to any other address change nothing, and reads from any other address return 0.
- R10: With `node_sel` low, the timer latch sets together with the tick's edge latch (R5). With `node_sel` high, it sets floor(P/4)+1 clocks after that point. P is the number of clocks between the last two tick edges, saturated at the counter maximum. No timer interrupt is taken until two ticks have been measured since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_sel | input | 1 | Node identity: 0 takes the timer at the tick edge, 1 a quarter period later |
| err_n | input | 1 | Active-low transaction-error event line, asynchronous |
| sysevt_n | input | 1 | Active-low bus system-event line, asynchronous |
| tmr_n | input | 1 | Active-low shared interval-timer tick, asynchronous |
| csr_wr | input | 1 | Write strobe for the CSR bus |
| csr_addr | input | ADDR_W | Register address for a read or write |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr`, combinational |
| ipi_irq | output | 1 | Interprocessor interrupt to the processor |
| sysevt_irq | output | 1 | System-event interrupt (bus event or node halt) |
| err_irq | output | 1 | Transaction-error interrupt |
| tmr_irq | output | 1 | Interval-timer interrupt |

## Verification
The bench builds the block with a 16-bit data bus and a 3-bit address. The register addresses are moved to 2 and 5, so writes to address 0 exercise the unmapped path. The timer counter is 8 bits wide. With that width, a 300-cycle gap between ticks saturates the period measurement, and the quarter-period delay at its ceiling is reachable in a short run. A behavioural model keeps per-line sample history and edge timestamps. It predicts every output and the read data on each clock. It covers both node phases, the first-tick blackout after reset, and an edge landing exactly on its own clear.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;

    // Request register field positions
    localparam int IPI_BIT      = 0;
    localparam int HALT_REQ_BIT = 1;
    localparam int SPARE_BIT    = 2;

    // Clear register field positions (sources share index with src_e)
    localparam int CLR_HALT_BIT = 3;
    localparam int FLD_W        = CLR_HALT_BIT + 1;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_ERR = 2'd0,
        SRC_SEV = 2'd1,
        SRC_TMR = 2'd2
    } src_e;

    typedef struct packed {
        logic spare;
        logic halt;
        logic ipi;
    } req_state_t;

    function automatic int src_idx(input src_e s);
        return int'(s);
    endfunction

endpackage

// File: rtl/nic_fall_sync.sv
`timescale 1ns/1ps
module nic_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic fall
);
    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '1;
            last_q <= 1'b1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], line_n};
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign fall = last_q & ~pipe_q[STAGES-1];

    assert_fall_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/nic_tmr_phase.sv
`timescale 1ns/1ps
module nic_tmr_phase #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic node_sel,
    output logic tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, period_q;
    logic             seen_q, armed_q;
    logic             fire;

    assign fire = armed_q && (cnt_q == (period_q >> 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
            seen_q   <= 1'b0;
            armed_q  <= 1'b0;
        end else if (fall) begin
            cnt_q   <= '0;
            seen_q  <= 1'b1;
            armed_q <= seen_q;
            if (seen_q)
                period_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        end else begin
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (fire)
                armed_q <= 1'b0;
        end
    end

    assign tick = node_sel ? fire : fall;

    assert_fire_once_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && !fall) |=> !fire);

endmodule

// File: rtl/nic_regs.sv
`timescale 1ns/1ps
module nic_regs
    import nic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic               wr_clr,
    input  logic [FLD_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] src_set,
    output req_state_t         req_q,
    output logic [NUM_SRC-1:0] lat_q
);
    logic [NUM_SRC-1:0] clr_mask;

    assign clr_mask = wr_clr ? wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            lat_q <= '0;
        end else begin
            if (wr_req) begin
                req_q.ipi   <= wdata[IPI_BIT];
                req_q.spare <= wdata[SPARE_BIT];
            end
            if (wr_req && wdata[HALT_REQ_BIT])
                req_q.halt <= 1'b1;
            else if (wr_clr && wdata[CLR_HALT_BIT])
                req_q.halt <= 1'b0;
            lat_q <= src_set | (lat_q & ~clr_mask);
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (req_q == '0 && lat_q == '0));

    assert_ipi_follow_R2: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (req_q.ipi == $past(wdata[IPI_BIT])));

    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (req_q.halt && !(wr_clr && wdata[CLR_HALT_BIT])) |=> req_q.halt);

    assert_halt_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wdata[CLR_HALT_BIT]) |=> !req_q.halt);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((lat_q & $past(wdata[NUM_SRC-1:0] & ~src_set)) == '0));

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (src_set != '0) |=> ((lat_q & $past(src_set)) == $past(src_set)));

endmodule

// File: rtl/node_irq_ctrl.sv
`timescale 1ns/1ps
module node_irq_ctrl
    import nic_pkg::*;
#(
    parameter int                DATA_W      = 64,
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REQ_ADDR    = 'd0,
    parameter logic [ADDR_W-1:0] CLR_ADDR    = 'd1,
    parameter int                SYNC_STAGES = 2,
    parameter int                CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              node_sel,
    input  logic              err_n,
    input  logic              sysevt_n,
    input  logic              tmr_n,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              ipi_irq,
    output logic              sysevt_irq,
    output logic              err_irq,
    output logic              tmr_irq
);
    logic [NUM_SRC-1:0] lines_n, falls, src_set, lat;
    logic               tmr_tick;
    logic               wr_req, wr_clr;
    req_state_t         req;
    logic               unused_wdata;

    assign lines_n = {tmr_n, sysevt_n, err_n};
    assign unused_wdata = ^csr_wdata;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
            nic_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .line_n(lines_n[i]),
                .fall  (falls[i])
            );
        end
    endgenerate

    nic_tmr_phase #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .fall    (falls[src_idx(SRC_TMR)]),
        .node_sel(node_sel),
        .tick    (tmr_tick)
    );

    always_comb begin
        src_set = falls;
        src_set[src_idx(SRC_TMR)] = tmr_tick;
    end

    assign wr_req = csr_wr && (csr_addr == REQ_ADDR);
    assign wr_clr = csr_wr && (csr_addr == CLR_ADDR);

    nic_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .wr_clr (wr_clr),
        .wdata  (csr_wdata[FLD_W-1:0]),
        .src_set(src_set),
        .req_q  (req),
        .lat_q  (lat)
    );

    always_comb begin
        csr_rdata = '0;
        if (csr_addr == REQ_ADDR) begin
            csr_rdata[IPI_BIT]      = req.ipi;
            csr_rdata[HALT_REQ_BIT] = req.halt;
            csr_rdata[SPARE_BIT]    = req.spare;
        end else if (csr_addr == CLR_ADDR) begin
            csr_rdata[NUM_SRC-1:0]  = lat;
            csr_rdata[CLR_HALT_BIT] = req.halt;
        end
    end

    assign ipi_irq    = req.ipi;
    assign sysevt_irq = lat[src_idx(SRC_SEV)] | req.halt;
    assign err_irq    = lat[src_idx(SRC_ERR)];
    assign tmr_irq    = lat[src_idx(SRC_TMR)];

    assert_sysevt_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sysevt_irq) |-> $past(falls[src_idx(SRC_SEV)] || (wr_req && csr_wdata[HALT_REQ_BIT])));

endmodule

// File: tb/tb_node_irq_ctrl.sv
`timescale 1ns/1ps
module tb_node_irq_ctrl;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam logic [AW-1:0] RA = 3'd2;
    localparam logic [AW-1:0] CA = 3'd5;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic node_sel = 1'b0;
    logic err_n = 1'b1, sysevt_n = 1'b1, tmr_n = 1'b1;
    logic csr_wr = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic ipi_irq, sysevt_irq, err_irq, tmr_irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    node_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .REQ_ADDR(RA), .CLR_ADDR(CA),
                    .SYNC_STAGES(2), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .node_sel(node_sel), .err_n(err_n), .sysevt_n(sysevt_n),
        .tmr_n(tmr_n), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .ipi_irq(ipi_irq), .sysevt_irq(sysevt_irq),
        .err_irq(err_irq), .tmr_irq(tmr_irq));

    // Behavioural reference model
    bit m_ipi, m_halt, m_spare;
    bit [2:0] m_lat;
    logic [2:0] hq[$];
    int edge_n, last_fall, period, target;
    bit seen;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd();
        logic [DW-1:0] v = '0;
        if (csr_addr == RA) begin v[0] = m_ipi; v[1] = m_halt; v[2] = m_spare; end
        else if (csr_addr == CA) begin v[2:0] = m_lat; v[3] = m_halt; end
        return v;
    endfunction

    task automatic model_step();
        logic [2:0] ev, setv, clr;
        bit fire;
        if (rst) begin
            m_ipi = 0; m_halt = 0; m_spare = 0; m_lat = '0;
            hq = '{3'b111, 3'b111, 3'b111};
            edge_n = 0; last_fall = 0; period = 0; target = -1; seen = 0;
        end else begin
            edge_n++;
            ev = hq[2] & ~hq[1];
            fire = (edge_n == target);
            if (fire) target = -1;
            if (ev[2]) begin
                if (seen) begin
                    period = (edge_n - last_fall > CMAX) ? CMAX : edge_n - last_fall;
                    target = edge_n + (period / 4) + 1;
                end else target = -1;
                last_fall = edge_n;
                seen = 1;
            end
            setv = {node_sel ? fire : ev[2], ev[1], ev[0]};
            clr = (csr_wr && csr_addr == CA) ? csr_wdata[2:0] : 3'b000;
            m_lat = setv | (m_lat & ~clr);
            if (csr_wr && csr_addr == RA) begin
                m_ipi = csr_wdata[0]; m_spare = csr_wdata[2];
                if (csr_wdata[1]) m_halt = 1;
            end else if (csr_wr && csr_addr == CA && csr_wdata[3]) m_halt = 0;
            hq.push_front({tmr_n, sysevt_n, err_n});
            void'(hq.pop_back());
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #1;
        if (!done) begin
            chk("R2", "ipi_irq", ipi_irq, m_ipi);
            chk("R4", "sysevt_irq", sysevt_irq, m_lat[1] | m_halt);
            chk("R5", "err_irq", err_irq, m_lat[0]);
            chk("R10", "tmr_irq", tmr_irq, m_lat[2]);
            chk("R8", "csr_rdata", csr_rdata, exp_rd());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        csr_wr = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        csr_addr = a;
        #0.5 d = csr_rdata;
    endtask

    task automatic tick(input int lo, input int hi);
        @(negedge clk); tmr_n = 0;
        idle(lo);
        tmr_n = 1;
        idle(hi);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        idle(3);
        // R1: reset state
        rd(RA, d); chk("R1", "req reg in reset", d, 0);
        rd(CA, d); chk("R1", "clr reg in reset", d, 0);
        chk("R1", "irq outputs in reset", {ipi_irq, sysevt_irq, err_irq, tmr_irq}, 0);
        @(negedge clk); rst = 0;
        idle(2);

        // R2: interprocessor request set and remove
        wr(RA, 16'h0001); chk("R2", "ipi set", ipi_irq, 1);
        rd(RA, d); chk("R2", "ipi readback", d[0], 1);
        wr(RA, 16'h0000); chk("R2", "ipi removed", ipi_irq, 0);

        // R9: scratch bit, zero bits, unmapped address
        wr(RA, 16'hFFFC); rd(RA, d); chk("R9", "scratch and zero bits", d, 16'h0004);
        wr(3'd0, 16'hFFFF); rd(RA, d); chk("R9", "unmapped write ignored", d, 16'h0004);
        rd(3'd0, d); chk("R9", "unmapped read zero", d, 0);

        // R3 / R4: node halt
        wr(RA, 16'h0002); chk("R3", "halt raises sysevt", sysevt_irq, 1);
        wr(RA, 16'h0000); rd(RA, d); chk("R3", "write 0 keeps halt", d[1], 1);
        wr(CA, 16'h0007); rd(CA, d); chk("R4", "other clears keep halt", d[3], 1);
        wr(CA, 16'h0008); chk("R4", "halt cleared", sysevt_irq, 0);

        // R5 / R6 / R8: error and bus event latches
        @(negedge clk); err_n = 0; idle(5); err_n = 1; idle(5);
        chk("R5", "error latched", err_irq, 1);
        rd(CA, d); chk("R8", "clr reg shows error", d, 16'h0001);
        wr(CA, 16'h0001); chk("R6", "error cleared", err_irq, 0);
        @(negedge clk); sysevt_n = 0; idle(6);
        chk("R5", "bus event latched", sysevt_irq, 1);
        wr(CA, 16'h0000); chk("R6", "write 0 keeps latch", sysevt_irq, 1);
        wr(CA, 16'h0002); chk("R6", "bus event cleared", sysevt_irq, 0);
        sysevt_n = 1; idle(6);
        chk("R5", "rising edge sets nothing", sysevt_irq, 0);

        // R7: edge lands on its own clear
        @(negedge clk); sysevt_n = 0;
        @(negedge clk);
        wr(CA, 16'h0002);
        chk("R7", "edge wins over clear", sysevt_irq, 1);
        sysevt_n = 1; idle(4);
        wr(CA, 16'h0002);

        // R10: node 0 phase
        node_sel = 0;
        repeat (4) tick(4, 4);
        idle(4);
        chk("R10", "node0 timer latched", tmr_irq, 1);
        wr(CA, 16'h0004);

        // R10: node 1 blackout after reset, then quarter-period phase
        @(negedge clk); rst = 1; node_sel = 1; idle(3); rst = 0;
        tick(5, 20);
        chk("R10", "no timer before two ticks", tmr_irq, 0);
        repeat (4) tick(6, 6);
        idle(8);
        chk("R10", "node1 timer latched", tmr_irq, 1);
        wr(CA, 16'h0004);
        tick(3, 297);
        tick(3, 297);
        idle(80);
        chk("R10", "saturated period timer", tmr_irq, 1);

        idle(5);
        finish_run();
    end
endmodule